// File: doc/BRIEF.md
# Bit-serial CRC-16 generator and checker

This block computes a 16-bit cyclic redundancy check over a stream of bytes. The generator polynomial is x^16 + x^15 + x^2 + 1, and each byte is taken most significant bit first. A byte is handed over with a valid/ready handshake. The block then folds that byte into its 16-stage register one bit per clock, and shows a busy flag while it does so. A synchronous clear empties the register at the start of each frame. The register is visible at all times as a high byte (stages 16 down to 9) and a low byte (stages 8 down to 1).

A transmitter uses the seal operation once its last data byte has gone in. The block takes either the register value or its bitwise complement as the check word. It presents that word as two bytes, high byte first, on a check-byte output so the sender can place them after the data. It also folds the two bytes back into its own register. A receiver feeds the data bytes and then the two received check bytes through the same path. It then reads two flags. One is set when the register holds zero, which is what a frame sealed with the plain check word leaves. The other is set when the register holds 0x800D, which is what a frame sealed with the complemented check word leaves. The complemented form keeps a frame that has been corrupted to all zeros from passing the check.

Top module: `crc16s_engine`

## Requirements
- R1: After reset the register is 0x0000, `in_ready` is 1, `busy` is 0, `chk_valid` is 0 and `residue_zero` is 1.
- R2: For each bit, the feedback is the incoming data bit XOR stage 16. The register shifts one place toward stage 16 and the feedback enters stage 1. When the feedback is 1, stages 3 and 16 also receive the inverted former contents of stages 2 and 15. Bytes enter most significant bit first.
- R3: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1 and `clr` and `seal_req` are both 0. `in_ready` is then 0 (and `busy` is 1) for exactly 8 cycles. The register does not change while the block is idle and nothing is accepted.
- R4: `clr` has priority over everything else. On the next cycle the register is 0x0000 and the block is idle, even if a byte is mid-shift or `in_valid` is high in the same cycle. A byte presented together with `clr` is dropped.
- R5: `crc_hi` carries stages 16..9 (stage 16 in bit 7) and `crc_lo` carries stages 8..1 (stage 1 in bit 0).
- R6: A seal is accepted on an idle cycle with `seal_req` = 1. The check word is the register value, or its complement when `seal_cpl` = 1. `chk_valid` is high on the 1st and 9th cycle after acceptance, with `chk_byte` giving the high byte and then the low byte. `busy` stays high for 16 cycles while both bytes are folded into the register.
- R7: After a seal with `seal_cpl` = 0 the register is 0x0000 and `residue_zero` = 1. After a seal with `seal_cpl` = 1 it is 0x800D and `residue_cpl` = 1.
- R8: When `seal_req` and `in_valid` are both high on an idle cycle, the seal is taken and the byte is ignored.
- R9: Feeding a frame's data bytes followed by its two check bytes leaves residue 0x0000 (plain check word) or 0x800D (complemented check word). Any single flipped bit in the frame leaves a different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of register and sequencer |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte, bit 7 enters first |
| in_ready | output | 1 | Block idle and able to take a byte or a seal |
| busy | output | 1 | Bits are being shifted |
| seal_req | input | 1 | Request to emit and fold in the check word |
| seal_cpl | input | 1 | Use the complemented register as check word |
| chk_valid | output | 1 | `chk_byte` carries a check byte this cycle |
| chk_byte | output | 8 | Check byte, high byte first |
| crc_hi | output | 8 | Register stages 16..9 |
| crc_lo | output | 8 | Register stages 8..1 |
| residue_zero | output | 1 | Register equals 0x0000 (read while idle) |
| residue_cpl | output | 1 | Register equals 0x800D (read while idle) |

## Verification
The hardest case to reach from the ports is an abort: a clear that lands in the middle of a byte shift, or in the same cycle as a new byte. The register must then end at zero and no partial result may be counted. The bench brings this about by raising `clr` a few cycles after a byte is accepted, and again together with `in_valid`. The scoreboard only retires an expected value after a complete 8- or 16-cycle busy run, so the aborted byte cannot be mistaken for a result. Random frames are sealed in both modes and then replayed as a receiver would, both unchanged and with one flipped bit, to cover the two fixed residues and the detection of a single-bit error.

// File: rtl/crc16s_pkg.sv
package crc16s_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_SEAL = 2'd2
  } phase_t;
endpackage

// File: rtl/crc16s_step.sv
// One-bit update of a Galois-style CRC register, taps chosen by POLY.
module crc16s_step #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic [CRC_W-1:0] cur,
  input  logic             din,
  output logic [CRC_W-1:0] nxt
);
  logic fb;
  assign fb = din ^ cur[CRC_W-1];

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = fb & POLY[i];
    end else begin : g_mid
      assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc16s_reg.sv
// CRC state register with clear priority and shift enable.
module crc16s_reg #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] step_nxt;
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  crc16s_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
    .cur (crc_q),
    .din (shift_bit),
    .nxt (step_nxt)
  );

  always_comb begin
    crc_en = clr | shift_en;
    crc_d  = clr ? '0 : step_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end
endmodule

// File: rtl/crc16s_seq.sv
// Byte/seal sequencer: loads a word into a shifter and feeds it MSB first.
module crc16s_seq
  import crc16s_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              seal_req,
  input  logic              seal_cpl,
  input  logic [CRC_W-1:0]  crc_now,
  output logic              in_ready,
  output logic              busy,
  output logic              shift_en,
  output logic              shift_bit,
  output logic              chk_valid,
  output logic [DATA_W-1:0] chk_byte
);
  localparam int CNT_W  = $clog2(CRC_W);
  localparam int LANE_W = $clog2(DATA_W);
  localparam int PAD_W  = CRC_W - DATA_W;
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] SEAL_LAST = CNT_W'(CRC_W - 1);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CRC_W-1:0] sh_q, sh_d;
  logic             st_en;
  logic             take_seal;
  logic             take_data;
  logic             last_bit;

  always_comb begin
    take_seal = (phase_q == PH_IDLE) && seal_req;
    take_data = (phase_q == PH_IDLE) && in_valid && !seal_req;
    last_bit  = ((phase_q == PH_DATA) && (cnt_q == DATA_LAST)) ||
                ((phase_q == PH_SEAL) && (cnt_q == SEAL_LAST));
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    if (clr) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (take_seal) begin
            phase_d = PH_SEAL;
            cnt_d   = '0;
            sh_d    = crc_now ^ {CRC_W{seal_cpl}};
          end else if (take_data) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
            sh_d    = {in_data, {PAD_W{1'b0}}};
          end
        end
        default: begin
          sh_d = {sh_q[CRC_W-2:0], 1'b0};
          if (last_bit) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
    st_en = clr || (phase_q != PH_IDLE) || take_seal || take_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (st_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end

  always_comb begin
    in_ready  = (phase_q == PH_IDLE);
    busy      = (phase_q != PH_IDLE);
    shift_en  = busy;
    shift_bit = sh_q[CRC_W-1];
    chk_valid = (phase_q == PH_SEAL) && (cnt_q[LANE_W-1:0] == '0);
    chk_byte  = sh_q[CRC_W-1 -: DATA_W];
  end
endmodule

// File: rtl/crc16s_engine.sv
module crc16s_engine #(
  parameter int              DATA_W      = 8,
  parameter int              CRC_W       = 16,
  parameter logic [CRC_W-1:0] POLY        = 16'h8005,
  parameter logic [CRC_W-1:0] CPL_RESIDUE = 16'h800D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  output logic                in_ready,
  output logic                busy,
  input  logic                seal_req,
  input  logic                seal_cpl,
  output logic                chk_valid,
  output logic [DATA_W-1:0]   chk_byte,
  output logic [CRC_W/2-1:0]  crc_hi,
  output logic [CRC_W/2-1:0]  crc_lo,
  output logic                residue_zero,
  output logic                residue_cpl
);
  localparam int HALF_W = CRC_W / 2;

  logic [CRC_W-1:0] crc_q;
  logic             shift_en;
  logic             shift_bit;

  crc16s_seq #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .seal_req  (seal_req),
    .seal_cpl  (seal_cpl),
    .crc_now   (crc_q),
    .in_ready  (in_ready),
    .busy      (busy),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .chk_valid (chk_valid),
    .chk_byte  (chk_byte)
  );

  crc16s_reg #(.CRC_W(CRC_W), .POLY(POLY)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .crc_q     (crc_q)
  );

  always_comb begin
    crc_hi       = crc_q[CRC_W-1 -: HALF_W];
    crc_lo       = crc_q[HALF_W-1:0];
    residue_zero = (crc_q == '0);
    residue_cpl  = (crc_q == CPL_RESIDUE);
  end
endmodule

// File: rtl/crc16s_engine_chk.sv
module crc16s_engine_chk #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               in_valid,
  input logic               in_ready,
  input logic               busy,
  input logic               seal_req,
  input logic               chk_valid,
  input logic [CRC_W/2-1:0] crc_hi,
  input logic [CRC_W/2-1:0] crc_lo
);
  localparam int RUN_W = $clog2(CRC_W) + 2;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R3
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !clr && !seal_req) |=> !in_ready);

  // R3
  idle_holds_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !seal_req && !clr) |=> ({crc_hi, crc_lo} == $past({crc_hi, crc_lo})));

  // R3
  busy_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_ready) && !$past(clr)) |-> ((run_q == RUN_W'(DATA_W)) || (run_q == RUN_W'(CRC_W))));

  // R4
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (({crc_hi, crc_lo} == '0) && in_ready));

  // R6
  chk_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> busy);

  // R6
  chk_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> !chk_valid);

  // R8
  seal_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && seal_req && !clr) |=> chk_valid);
endmodule

bind crc16s_engine crc16s_engine_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .busy      (busy),
  .seal_req  (seal_req),
  .chk_valid (chk_valid),
  .crc_hi    (crc_hi),
  .crc_lo    (crc_lo)
);

// File: tb/crc16s_engine_test.sv
`timescale 1ns/1ps
module crc16s_engine_test;
  logic       clk;
  logic       rst_n;
  logic       clr;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       busy;
  logic       seal_req;
  logic       seal_cpl;
  logic       chk_valid;
  logic [7:0] chk_byte;
  logic [7:0] crc_hi;
  logic [7:0] crc_lo;
  logic       residue_zero;
  logic       residue_cpl;

  int checks = 0;
  int fails  = 0;

  logic [15:0] model;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  byte_q[$];

  crc16s_engine uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .busy(busy), .seal_req(seal_req), .seal_cpl(seal_cpl),
    .chk_valid(chk_valid), .chk_byte(chk_byte), .crc_hi(crc_hi), .crc_lo(crc_lo),
    .residue_zero(residue_zero), .residue_cpl(residue_cpl)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Stage view: flip stages 2 and 15, shift up, feedback into stage 1.
  function automatic logic [15:0] ref_bit(input logic [15:0] r, input logic d);
    logic fb;
    fb = d ^ r[15];
    return {r[14] ^ fb, r[13:2], r[1] ^ fb, r[0], fb};
  endfunction

  function automatic logic [15:0] ref_byte(input logic [15:0] r, input logic [7:0] b);
    logic [15:0] t;
    t = r;
    for (int i = 7; i >= 0; i--) t = ref_bit(t, b[i]);
    return t;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    wait_idle();
    in_valid = 1'b1;
    in_data  = b;
    model    = ref_byte(model, b);
    exp_q.push_back(model);
    tag_q.push_back("R2 byte result");
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic seal(input logic cpl, output logic [15:0] word);
    wait_idle();
    seal_req = 1'b1;
    seal_cpl = cpl;
    word = model ^ {16{cpl}};
    byte_q.push_back(word[15:8]);
    byte_q.push_back(word[7:0]);
    model = ref_byte(ref_byte(model, word[15:8]), word[7:0]);
    exp_q.push_back(model);
    tag_q.push_back("R7 sealed residue");
    @(negedge clk);
    seal_req = 1'b0;
  endtask

  task automatic clear();
    wait_idle();
    clr   = 1'b1;
    model = '0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // Scoreboard monitor: retires an expected value after a full busy run.
  int run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_valid) begin
        if (byte_q.size() == 0) check("R6 unexpected check byte", {8'h00, chk_byte}, 16'hxxxx);
        else check("R6 check byte", {8'h00, chk_byte}, {8'h00, byte_q.pop_front()});
      end
      if (busy) begin
        run++;
      end else begin
        if (run == 8 || run == 16) begin
          if (exp_q.size() == 0) check("R3 unexpected completion", {crc_hi, crc_lo}, 16'hxxxx);
          else check(tag_q.pop_front(), {crc_hi, crc_lo}, exp_q.pop_front());
        end
        run = 0;
      end
    end
  end

  task automatic run_frame(input int len, input logic cpl);
    logic [7:0]  frame [16];
    logic [15:0] word;
    logic [15:0] want;
    int          k;
    want = cpl ? 16'h800D : 16'h0000;
    for (int i = 0; i < len; i++) frame[i] = 8'($urandom);
    clear();
    for (int i = 0; i < len; i++) send_byte(frame[i]);
    seal(cpl, word);
    wait_idle();
    check(cpl ? "R7 residue_cpl flag" : "R7 residue_zero flag",
          {15'd0, cpl ? residue_cpl : residue_zero}, 16'd1);
    // receiver pass, intact
    clear();
    for (int i = 0; i < len; i++) send_byte(frame[i]);
    send_byte(word[15:8]);
    send_byte(word[7:0]);
    wait_idle();
    check("R9 intact frame residue", {crc_hi, crc_lo}, want);
    // receiver pass, one flipped bit
    k = $urandom_range(len + 1, 0);
    clear();
    for (int i = 0; i < len + 2; i++) begin
      logic [7:0] b;
      b = (i < len) ? frame[i] : ((i == len) ? word[15:8] : word[7:0]);
      if (i == k) b = b ^ (8'h01 << $urandom_range(7, 0));
      send_byte(b);
    end
    wait_idle();
    check("R9 flipped bit detected", {15'd0, ({crc_hi, crc_lo} != want)}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [15:0] held;
    int          cnt;
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_data = '0;
    seal_req = 1'b0; seal_cpl = 1'b0; model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 crc", {crc_hi, crc_lo}, 16'h0000);
    check("R1 in_ready", {15'd0, in_ready}, 16'd1);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 chk_valid", {15'd0, chk_valid}, 16'd0);
    check("R1 residue_zero", {15'd0, residue_zero}, 16'd1);

    // R2/R5 single byte, halves; R3 busy length
    send_byte(8'h80);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R3 busy cycles", 16'(cnt), 16'd8);
    check("R5 crc_hi", {8'h00, crc_hi}, {8'h00, model[15:8]});
    check("R5 crc_lo", {8'h00, crc_lo}, {8'h00, model[7:0]});
    send_byte(8'h3C);
    send_byte(8'hFF);
    send_byte(8'h00);

    // R3 idle with no accept leaves register alone
    wait_idle();
    held = {crc_hi, crc_lo};
    for (int i = 0; i < 5; i++) begin in_data = 8'($urandom); @(negedge clk); end
    check("R3 idle hold", {crc_hi, crc_lo}, held);

    // R4 clear mid-shift
    wait_idle();
    in_valid = 1'b1; in_data = 8'hA7;
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0; model = '0;
    check("R4 abort crc", {crc_hi, crc_lo}, 16'h0000);
    check("R4 abort idle", {15'd0, in_ready}, 16'd1);
    // R4 clear together with a byte
    send_byte(8'h5A);
    wait_idle();
    clr = 1'b1; in_valid = 1'b1; in_data = 8'hFF;
    @(negedge clk); clr = 1'b0; in_valid = 1'b0; model = '0;
    check("R4 byte dropped busy", {15'd0, busy}, 16'd0);
    check("R4 byte dropped crc", {crc_hi, crc_lo}, 16'h0000);

    // R8 seal wins over a byte in the same cycle
    clear();
    send_byte(8'h12);
    send_byte(8'h34);
    wait_idle();
    in_valid = 1'b1; in_data = 8'hC3; seal_req = 1'b1; seal_cpl = 1'b0;
    w = model;
    byte_q.push_back(w[15:8]);
    byte_q.push_back(w[7:0]);
    model = ref_byte(ref_byte(model, w[15:8]), w[7:0]);
    exp_q.push_back(model);
    tag_q.push_back("R8 seal taken");
    @(negedge clk); in_valid = 1'b0; seal_req = 1'b0;
    wait_idle();
    check("R8 residue after seal", {crc_hi, crc_lo}, 16'h0000);

    // R6/R7/R9 random frames in both modes
    for (int f = 0; f < 8; f++) run_frame($urandom_range(12, 1), f[0]);
    // empty frame in complemented mode
    clear();
    seal(1'b1, w);
    wait_idle();
    check("R7 empty frame cpl", {crc_hi, crc_lo}, 16'h800D);

    repeat (4) @(negedge clk);
    check("R6 check bytes drained", 16'(byte_q.size()), 16'd0);
    check("R2 results drained", 16'(exp_q.size()), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule